// File: doc/BRIEF.md
# Multi-Gate Hardware Semaphore Unit

A bank of lock gates shared by several bus masters. Each request port carries address, write data, write and read strobes, plus the index and domain ID of the master driving it. Each gate is an 8-bit register. Its low nibble holds the owner's index plus one, and zero in that nibble means the gate is free. Bits [5:4] hold the owner's domain. Bits [7:6] always read zero.

Software takes a gate by writing its own index plus one. It then reads the byte back and compares it with the owner and domain it expects. It gives the gate back by writing zero. A separate reset register lets any master force gates free. The first write carries an arming key, and the second carries a firing key plus a gate number. A gate number at or above the gate count frees every gate.

Top module: `sema_gate_bank`

## Requirements
- R1: After reset every gate reads 0x00, and the reset register reads 0x0000.
- R2: A write to a free gate whose value in bits [3:0] equals the writer's master index plus one locks the gate. Reads then return the writer's domain in bits [5:4] and index+1 in bits [3:0]. Any other nonzero value written to a free gate leaves it free.
- R3: A lock write from a master that does not own a held gate leaves the gate unchanged.
- R4: The owner frees its gate by writing 0. A zero from a non-owner is ignored. A nonzero value from the owner is ignored.
- R5: When several ports write valid lock values to the same free gate in one cycle, the lowest master index wins, whatever the port number.
- R6: The reset register reads {target gate number [15:8], 6'b0, sequencer state [1:0]}. The state is 0 when idle, 1 after an accepted arming key (0xE2 in bits [7:0]) and 2 during the clear cycle. After the clear cycle it returns to 0.
- R7: An arming write followed by a write of 0x1D in bits [7:0] with gate number N < gate count in bits [15:8] frees only gate N. The gate reads zero from the second edge after the firing write.
- R8: A firing write whose gate number is at or above the gate count frees every gate.
- R9: A write to the reset register other than 0x1D while armed returns the sequencer to idle without clearing anything. A firing write while idle has no effect.
- R10: While idle, a reset-register write without 0xE2 in bits [7:0] leaves the sequencer idle.
- R11: Read data appears on rdata_o the cycle after the read strobe. Addresses above the reset register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | N_PORTS | Write strobe per port |
| re_i | input | N_PORTS | Read strobe per port |
| addr_i | input | N_PORTS*AW | Address per port. Gates sit at 0..N_GATES-1 and the reset register at N_GATES |
| wdata_i | input | N_PORTS*16 | Write data per port |
| mst_i | input | N_PORTS*4 | Master index of the requester per port |
| dom_i | input | N_PORTS*2 | Domain ID of the requester per port |
| rdata_o | output | N_PORTS*16 | Registered read data per port |

## Verification
A gate write changes gate state at the edge that samples it, and the firing key moves the sequencer into its clear state at that same edge. The gates become zero one edge later. Read data is registered, so a value appears one edge after the strobe. All bench tasks start and end at a falling edge. Each one drives inputs there and samples rdata_o at the next falling edge. A status read issued right after the firing write therefore catches the clear state, and the following gate read sees the cleared value.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int unsigned MST_W  = 4;
  localparam int unsigned DOM_W  = 2;
  localparam int unsigned DATA_W = 16;
  localparam logic [7:0] KEY_ARM  = 8'hE2;
  localparam logic [7:0] KEY_FIRE = 8'h1D;

  typedef struct packed {
    logic [DOM_W-1:0] dom;
    logic [MST_W-1:0] mst;
  } gate_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_CLEAR = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sema_gate_slot.sv
module sema_gate_slot
  import sema_pkg::*;
#(
  parameter int unsigned N_PORTS = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N_PORTS-1:0]              hit_i,
  input  logic [N_PORTS-1:0][MST_W-1:0]   val_i,
  input  logic [N_PORTS-1:0][MST_W-1:0]   mst_i,
  input  logic [N_PORTS-1:0][DOM_W-1:0]   dom_i,
  input  logic                            clr_i,
  output gate_t                           gate_o
);
  gate_t            gate_q, gate_d;
  logic             is_free, found, win_lock, can_lock, can_free;
  logic [MST_W-1:0] win_mst;
  logic [DOM_W-1:0] win_dom;
  logic [MST_W:0]   mine;

  assign is_free = (gate_q.mst == '0);

  always_comb begin
    found    = 1'b0;
    win_lock = 1'b0;
    win_mst  = '0;
    win_dom  = '0;
    mine     = '0;
    can_lock = 1'b0;
    can_free = 1'b0;
    for (int p = 0; p < int'(N_PORTS); p++) begin
      mine     = {1'b0, mst_i[p]} + 1'b1;
      can_lock = is_free && ({1'b0, val_i[p]} == mine);
      can_free = !is_free && ({1'b0, gate_q.mst} == mine) && (val_i[p] == '0);
      // lowest master index wins among effective writers
      if (hit_i[p] && (can_lock || can_free) && (!found || mst_i[p] < win_mst)) begin
        found    = 1'b1;
        win_mst  = mst_i[p];
        win_dom  = dom_i[p];
        win_lock = can_lock;
      end
    end
    gate_d = gate_q;
    if (clr_i) begin
      gate_d = '0;
    end else if (found) begin
      if (win_lock) begin
        gate_d.dom = win_dom;
        gate_d.mst = MST_W'(win_mst + 1'b1);
      end else begin
        gate_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/sema_rst_seq.sv
module sema_rst_seq
  import sema_pkg::*;
#(
  parameter int unsigned N_GATES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_valid_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output seq_state_e         state_o,
  output logic [7:0]         tgt_o,
  output logic [N_GATES-1:0] clr_o
);
  localparam logic [7:0] ALL_THR = 8'(N_GATES);

  seq_state_e state_q;
  logic [7:0] tgt_q;
  logic [7:0] key;

  assign key = wr_data_i[7:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE:  if (wr_valid_i && key == KEY_ARM) state_q <= SEQ_ARMED;
        SEQ_ARMED: if (wr_valid_i) begin
          if (key == KEY_FIRE) begin
            state_q <= SEQ_CLEAR;
            tgt_q   <= wr_data_i[15:8];
          end else begin
            state_q <= SEQ_IDLE;
          end
        end
        SEQ_CLEAR: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < int'(N_GATES); g++) begin : g_clr
    assign clr_o[g] = (state_q == SEQ_CLEAR) && ((tgt_q >= ALL_THR) || (tgt_q == 8'(g)));
  end

  assign state_o = state_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/sema_rd_port.sv
module sema_rd_port
  import sema_pkg::*;
#(
  parameter int unsigned N_GATES = 16,
  parameter int unsigned AW      = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     re_i,
  input  logic [AW-1:0]            addr_i,
  input  gate_t [N_GATES-1:0]      gates_i,
  input  seq_state_e               state_i,
  input  logic [7:0]               tgt_i,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam logic [AW-1:0] RST_ADDR = AW'(N_GATES);

  logic [DATA_W-1:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    for (int g = 0; g < int'(N_GATES); g++) begin
      if (addr_i == AW'(g)) rd_d = {8'h00, 2'b00, gates_i[g]};
    end
    if (addr_i == RST_ADDR) rd_d = {tgt_i, 6'b0, state_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sema_gate_bank.sv
module sema_gate_bank
  import sema_pkg::*;
#(
  parameter int unsigned N_GATES = 16,
  parameter int unsigned N_PORTS = 2,
  localparam int unsigned AW     = $clog2(N_GATES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          we_i,
  input  logic [N_PORTS-1:0]          re_i,
  input  logic [N_PORTS*AW-1:0]       addr_i,
  input  logic [N_PORTS*DATA_W-1:0]   wdata_i,
  input  logic [N_PORTS*MST_W-1:0]    mst_i,
  input  logic [N_PORTS*DOM_W-1:0]    dom_i,
  output logic [N_PORTS*DATA_W-1:0]   rdata_o
);
  localparam logic [AW-1:0] RST_ADDR = AW'(N_GATES);

  logic [N_PORTS-1:0][AW-1:0]     p_addr;
  logic [N_PORTS-1:0][DATA_W-1:0] p_wdata;
  logic [N_PORTS-1:0][MST_W-1:0]  p_val, p_mst;
  logic [N_PORTS-1:0][DOM_W-1:0]  p_dom;
  logic [N_GATES-1:0][N_PORTS-1:0] hit;

  gate_t [N_GATES-1:0] gate_q;
  logic  [N_GATES-1:0] clr_vec;
  seq_state_e          seq_state;
  logic [7:0]          seq_tgt;
  logic                rst_wr_valid;
  logic [DATA_W-1:0]   rst_wr_data;

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_port
    assign p_addr[p]  = addr_i[p*AW +: AW];
    assign p_wdata[p] = wdata_i[p*DATA_W +: DATA_W];
    assign p_val[p]   = p_wdata[p][MST_W-1:0];
    assign p_mst[p]   = mst_i[p*MST_W +: MST_W];
    assign p_dom[p]   = dom_i[p*DOM_W +: DOM_W];

    sema_rd_port #(.N_GATES(N_GATES), .AW(AW)) u_rd (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .re_i    (re_i[p]),
      .addr_i  (p_addr[p]),
      .gates_i (gate_q),
      .state_i (seq_state),
      .tgt_i   (seq_tgt),
      .rdata_o (rdata_o[p*DATA_W +: DATA_W])
    );
  end

  for (genvar g = 0; g < int'(N_GATES); g++) begin : g_gate
    for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_hit
      assign hit[g][p] = we_i[p] && (p_addr[p] == AW'(g));
    end

    sema_gate_slot #(.N_PORTS(N_PORTS)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[g]),
      .val_i  (p_val),
      .mst_i  (p_mst),
      .dom_i  (p_dom),
      .clr_i  (clr_vec[g]),
      .gate_o (gate_q[g])
    );
  end

  // reset register: lowest port wins a same-cycle collision
  always_comb begin
    rst_wr_valid = 1'b0;
    rst_wr_data  = '0;
    for (int p = int'(N_PORTS) - 1; p >= 0; p--) begin
      if (we_i[p] && p_addr[p] == RST_ADDR) begin
        rst_wr_valid = 1'b1;
        rst_wr_data  = p_wdata[p];
      end
    end
  end

  sema_rst_seq #(.N_GATES(N_GATES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (rst_wr_valid),
    .wr_data_i  (rst_wr_data),
    .state_o    (seq_state),
    .tgt_o      (seq_tgt),
    .clr_o      (clr_vec)
  );
endmodule

// File: rtl/sema_gate_bank_chk.sv
module sema_gate_bank_chk
  import sema_pkg::*;
#(
  parameter int unsigned N_GATES = 16,
  parameter int unsigned N_PORTS = 2,
  localparam int unsigned AW     = $clog2(N_GATES + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input gate_t [N_GATES-1:0]        gate_i,
  input logic  [N_GATES-1:0]        clr_i,
  input seq_state_e                 state_i,
  input logic                       rst_wr_valid_i,
  input logic [7:0]                 rst_wr_key_i,
  input logic [N_PORTS-1:0]         re_i,
  input logic [N_PORTS*AW-1:0]      addr_i,
  input logic [N_PORTS*DATA_W-1:0]  rdata_i
);
  for (genvar g = 0; g < int'(N_GATES); g++) begin : g_gate
    assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] |=> gate_i[g] == '0);
    assert_lock_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_i[g].mst != '0 && !clr_i[g]) |=> (gate_i[g].mst == '0 || gate_i[g] == $past(gate_i[g])));
  end

  assert_clr_in_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |-> state_i == SEQ_CLEAR);
  assert_clear_to_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == SEQ_CLEAR |=> state_i == SEQ_IDLE);
  assert_arm_needs_key_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == SEQ_IDLE && !(rst_wr_valid_i && rst_wr_key_i == KEY_ARM)) |=> state_i == SEQ_IDLE);
  assert_bad_fire_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == SEQ_ARMED && rst_wr_valid_i && rst_wr_key_i != KEY_FIRE) |=> state_i == SEQ_IDLE);

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_rd
    assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (re_i[p] && addr_i[p*AW +: AW] > AW'(N_GATES)) |=> rdata_i[p*DATA_W +: DATA_W] == '0);
  end
endmodule

bind sema_gate_bank sema_gate_bank_chk #(.N_GATES(N_GATES), .N_PORTS(N_PORTS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .gate_i         (gate_q),
  .clr_i          (clr_vec),
  .state_i        (seq_state),
  .rst_wr_valid_i (rst_wr_valid),
  .rst_wr_key_i   (rst_wr_data[7:0]),
  .re_i           (re_i),
  .addr_i         (addr_i),
  .rdata_i        (rdata_o)
);

// File: tb/sema_gate_bank_test.sv
`timescale 1ns/1ps
module sema_gate_bank_test;
  localparam int NG = 16;
  localparam int NP = 2;
  localparam int AW = 5;
  localparam int RA = NG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    we = '0, re = '0;
  logic [NP*AW-1:0] addr = '0;
  logic [NP*16-1:0] wdata = '0;
  logic [NP*4-1:0]  mst = '0;
  logic [NP*2-1:0]  dom = '0;
  logic [NP*16-1:0] rdata;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sema_gate_bank #(.N_GATES(NG), .N_PORTS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .mst_i(mst), .dom_i(dom), .rdata_o(rdata)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_port(int p, int a, int d, int m, int dm);
    addr[p*AW +: AW] = a[AW-1:0];
    wdata[p*16 +: 16] = d[15:0];
    mst[p*4 +: 4] = m[3:0];
    dom[p*2 +: 2] = dm[1:0];
  endtask

  // tasks start and end at a falling edge
  task automatic wr(int p, int a, int d, int m, int dm);
    set_port(p, a, d, m, dm);
    we[p] = 1'b1;
    @(negedge clk);
    we[p] = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    addr[0 +: AW] = a[AW-1:0];
    re[0] = 1'b1;
    @(negedge clk);
    re[0] = 1'b0;
    v = rdata[0 +: 16];
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(0, v);  chk("R1", "gate0 after reset", v, 16'h0000);
    rd(15, v); chk("R1", "gate15 after reset", v, 16'h0000);
    rd(RA, v); chk("R1", "reset reg after reset", v, 16'h0000);
  endtask

  task automatic t_lock;
    logic [15:0] v;
    wr(0, 4, 3, 2, 1);
    rd(4, v); chk("R2", "lock by master 2 dom 1", v, 16'h0013);
    wr(1, 6, 1, 5, 0);
    rd(6, v); chk("R2", "wrong lock value ignored", v, 16'h0000);
  endtask

  task automatic t_held;
    logic [15:0] v;
    wr(1, 4, 8, 7, 2);
    rd(4, v); chk("R3", "held gate keeps owner", v, 16'h0013);
  endtask

  task automatic t_unlock;
    logic [15:0] v;
    wr(1, 4, 0, 7, 2);
    rd(4, v); chk("R4", "non-owner zero ignored", v, 16'h0013);
    wr(0, 4, 5, 2, 1);
    rd(4, v); chk("R4", "owner nonzero ignored", v, 16'h0013);
    wr(0, 4, 0, 2, 1);
    rd(4, v); chk("R4", "owner unlock", v, 16'h0000);
  endtask

  task automatic t_contend;
    logic [15:0] v;
    set_port(0, 2, 10, 9, 3);
    set_port(1, 2, 4, 3, 0);
    we = 2'b11;
    @(negedge clk);
    we = 2'b00;
    rd(2, v); chk("R5", "lower master index wins", v, 16'h0004);
  endtask

  task automatic t_rst_one;
    logic [15:0] v;
    wr(0, 1, 1, 0, 0);
    wr(1, 3, 2, 1, 2);
    wr(0, RA, 16'h00E2, 0, 0);
    rd(RA, v); chk("R6", "status armed", v, 16'h0001);
    wr(1, RA, 16'h031D, 6, 0);
    rd(RA, v); chk("R6", "status clearing", v, 16'h0302);
    rd(3, v);  chk("R7", "target gate cleared", v, 16'h0000);
    rd(1, v);  chk("R7", "other gate kept", v, 16'h0001);
    rd(RA, v); chk("R6", "status back to idle", v, 16'h0300);
  endtask

  task automatic t_rst_all;
    logic [15:0] v;
    wr(0, 0, 1, 0, 0);
    wr(1, 15, 3, 2, 3);
    wr(0, RA, 16'h00E2, 0, 0);
    wr(0, RA, 16'h101D, 0, 0);
    @(negedge clk);
    rd(0, v);  chk("R8", "gate0 cleared by all", v, 16'h0000);
    rd(1, v);  chk("R8", "gate1 cleared by all", v, 16'h0000);
    rd(15, v); chk("R8", "gate15 cleared by all", v, 16'h0000);
  endtask

  task automatic t_bad_key;
    logic [15:0] v;
    wr(0, 5, 5, 4, 1);
    wr(0, RA, 16'h00E2, 0, 0);
    wr(0, RA, 16'h0555, 0, 0);
    rd(RA, v); chk("R9", "bad fire key returns idle", v, 16'h1000);
    wr(0, RA, 16'h051D, 0, 0);
    @(negedge clk);
    rd(RA, v); chk("R9", "fire without arm stays idle", v, 16'h1000);
    rd(5, v);  chk("R9", "gate kept after bad sequence", v, 16'h0015);
  endtask

  task automatic t_no_arm;
    logic [15:0] v;
    wr(1, RA, 16'h0012, 0, 0);
    rd(RA, v); chk("R10", "non-key write keeps idle", v, 16'h1000);
  endtask

  task automatic t_read;
    logic [15:0] v;
    rd(20, v); chk("R11", "unmapped address", v, 16'h0000);
    rd(5, v);  chk("R11", "data one cycle after strobe", v, 16'h0015);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_held();
    t_unlock();
    t_contend();
    t_rst_one();
    t_rst_all();
    t_bad_key();
    t_no_arm();
    t_read();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule